// File: doc/BRIEF.md
# SPI FIFO Status and Interrupt Unit

This block keeps track of the two word FIFOs that sit between an SPI master's register interface and its serial shifter. The transmit FIFO is filled by the host and drained by the shifter. The receive FIFO is filled by the shifter and drained by the host. Each FIFO stores 32-bit words and has its own push and pop ports. The block reports occupancy, sticky error and threshold flags for each FIFO. It also passes two transfer-state flags from the shifter into a single 12-bit live status word.

Interrupts come from that status word by edges, not by levels. A cause bit is captured only in the cycle after its status flag goes from 0 to 1. Software clears causes by writing ones. A mask register chooses which captured causes reach a registered interrupt line. A flush request empties both FIFOs and clears their sticky flags. Its busy indication clears itself once the flush has been applied.

Top module: `spi_fifo_irq_unit`

## Requirements
- R1: After reset both FIFOs are empty, no sticky flag is set, the cause and mask registers are zero, `irq` and `flush_busy` are 0, and no cause is captured while the status word only holds its level.
- R2: Each FIFO returns words in push order on its `*_rdata` port, reports full at DEPTH_WORDS words and empty at zero, and accepts a push together with a pop while full without any overflow.
- R3: Occupancy in bytes is words times 4. Receive-ready is 1 when that byte count is greater than `rx_thr`. Transmit-ready is 1 when the free byte count (8 minus occupancy) is greater than `tx_thr`. Software programs `rx_thr` as bytes per word minus 1 and `tx_thr` as 7 minus bytes per word.
- R4: Status bit positions: 0 transfer done, 1 transfer ready, 2 receive ready, 3 transmit ready, 4 receive empty, 5 receive full, 6 transmit empty, 7 transmit full, 8 receive underflow, 9 receive overflow, 10 transmit underflow, 11 transmit overflow.
- R5: A push into a full FIFO without a pop drops the word and sets that FIFO's overflow flag. A pop from an empty FIFO sets its underflow flag. Both flags stay set until a flush or a reset.
- R6: A `flush_req` pulse makes `flush_busy` read 1 after the next clock edge. At the following edge both FIFOs empty, all four sticky flags clear, and `flush_busy` returns to 0 by itself.
- R7: A cause bit is set at the first clock edge at which its status bit is 1 after having been 0 at the edge before. A status bit that stays 1 never sets its cause again, even when it is newly unmasked.
- R8: Asserting `cause_clr_we` clears every cause bit that is 1 in `cause_clr_bits`, and all ones clears every cause. A rising edge in the same cycle wins over the clear.
- R9: `irq` is 1 one cycle after any bit is set in both `cause` and the mask. An all-zero mask holds `irq` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_push | input | 1 | Host writes a word into the transmit FIFO |
| tx_wdata | input | 32 | Word to write into the transmit FIFO |
| tx_pop | input | 1 | Shifter takes the head word of the transmit FIFO |
| tx_rdata | output | 32 | Head word of the transmit FIFO |
| rx_push | input | 1 | Shifter writes a word into the receive FIFO |
| rx_wdata | input | 32 | Word to write into the receive FIFO |
| rx_pop | input | 1 | Host takes the head word of the receive FIFO |
| rx_rdata | output | 32 | Head word of the receive FIFO |
| rx_thr | input | 3 | Receive-ready byte threshold |
| tx_thr | input | 3 | Transmit-ready free-byte threshold |
| xfer_done | input | 1 | Transfer-done flag from the shifter |
| xfer_rdy | input | 1 | Transfer-ready flag from the shifter |
| flush_req | input | 1 | Request to empty both FIFOs |
| flush_busy | output | 1 | Flush pending, clears itself |
| cause_clr_we | input | 1 | Write-one-to-clear strobe for the cause register |
| cause_clr_bits | input | 12 | Cause bits to clear |
| mask_we | input | 1 | Mask register write strobe |
| mask_wdata | input | 12 | New mask value |
| status | output | 12 | Live status word |
| cause | output | 12 | Captured interrupt causes |
| irq | output | 1 | Registered interrupt line |

## Verification
On every cycle the assertions check these properties: occupancy stays within bounds, full and empty are never both set, receive-ready implies a non-empty FIFO, overflow stays sticky, a flush leaves both FIFOs empty, every newly set cause matches a detected rising edge, a clear takes effect unless a rise coincides with it, and `irq` follows the masked causes one cycle later. Only the bench scenarios can show the things that depend on stimulus. These are word ordering and dropped words, the exact status word after each push and pop, the full threshold table for every occupancy, and the cases where a held level or a newly unmasked level raises nothing.

// File: rtl/spi_fifo_irq_pkg.sv
package spi_fifo_irq_pkg;

  localparam int NSTAT = 12;

  localparam int ST_XDONE    = 0;
  localparam int ST_XRDY     = 1;
  localparam int ST_RX_RDY   = 2;
  localparam int ST_TX_RDY   = 3;
  localparam int ST_RX_EMPTY = 4;
  localparam int ST_RX_FULL  = 5;
  localparam int ST_TX_EMPTY = 6;
  localparam int ST_TX_FULL  = 7;
  localparam int ST_RX_UDF   = 8;
  localparam int ST_RX_OVF   = 9;
  localparam int ST_TX_UDF   = 10;
  localparam int ST_TX_OVF   = 11;

  function automatic logic [7:0] occ_bytes(logic [7:0] words, logic [7:0] bpw);
    return words * bpw;
  endfunction

  function automatic logic rx_is_ready(logic [7:0] bytes, logic [7:0] thr);
    return bytes > thr;
  endfunction

  function automatic logic tx_is_ready(logic [7:0] bytes, logic [7:0] cap, logic [7:0] thr);
    return (cap - bytes) > thr;
  endfunction

  function automatic logic [NSTAT-1:0] rising(logic [NSTAT-1:0] now, logic [NSTAT-1:0] prev);
    return now & ~prev;
  endfunction

  function automatic logic [NSTAT-1:0] cause_next(logic [NSTAT-1:0] cur,
                                                  logic [NSTAT-1:0] rise,
                                                  logic [NSTAT-1:0] clr);
    return (cur & ~clr) | rise;
  endfunction

endpackage

// File: rtl/spi_fifo_track.sv
module spi_fifo_track #(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 2,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              push,
  input  logic [WORD_W-1:0] wdata,
  input  logic              pop,
  output logic [WORD_W-1:0] rdata,
  output logic [CNT_W-1:0]  count,
  output logic              full,
  output logic              empty,
  output logic              ovf,
  output logic              udf,
  output logic              push_ok,
  output logic              pop_ok
);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;

  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push && !clear && (!full || pop);
  assign pop_ok  = pop && !clear && !empty;
  assign rdata   = mem[rd_ptr];

  function automatic logic [PTR_W-1:0] adv(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      ovf    <= 1'b0;
      udf    <= 1'b0;
    end else if (clear) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      ovf    <= 1'b0;
      udf    <= 1'b0;
    end else begin
      if (push_ok) wr_ptr <= adv(wr_ptr);
      if (pop_ok)  rd_ptr <= adv(rd_ptr);
      if (push_ok && !pop_ok)      count <= count + CNT_W'(1);
      else if (pop_ok && !push_ok) count <= count - CNT_W'(1);
      if (push && full && !pop) ovf <= 1'b1;
      if (pop && empty)         udf <= 1'b1;
    end
  end

endmodule

// File: rtl/spi_irq_cause.sv
module spi_irq_cause
  import spi_fifo_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSTAT-1:0] status,
  input  logic             clr_we,
  input  logic [NSTAT-1:0] clr_bits,
  input  logic             mask_we,
  input  logic [NSTAT-1:0] mask_wdata,
  output logic [NSTAT-1:0] cause,
  output logic [NSTAT-1:0] mask,
  output logic             irq,
  output logic [NSTAT-1:0] rise
);

  logic [NSTAT-1:0] status_q;
  logic             primed;

  assign rise = primed ? rising(status, status_q) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      primed   <= 1'b0;
      cause    <= '0;
      mask     <= '0;
      irq      <= 1'b0;
    end else begin
      status_q <= status;
      primed   <= 1'b1;
      cause    <= cause_next(cause, rise, clr_we ? clr_bits : '0);
      if (mask_we) mask <= mask_wdata;
      irq      <= |(cause & mask);
    end
  end

endmodule

// File: rtl/spi_fifo_irq_unit.sv
module spi_fifo_irq_unit
  import spi_fifo_irq_pkg::*;
#(
  parameter int WORD_W      = 32,
  parameter int DEPTH_WORDS = 2,
  parameter int BYTES_PW    = 4,
  parameter int THR_W       = 3,
  localparam int CNT_W      = $clog2(DEPTH_WORDS + 1),
  localparam int CAP_BYTES  = DEPTH_WORDS * BYTES_PW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_push,
  input  logic [WORD_W-1:0] tx_wdata,
  input  logic              tx_pop,
  output logic [WORD_W-1:0] tx_rdata,
  input  logic              rx_push,
  input  logic [WORD_W-1:0] rx_wdata,
  input  logic              rx_pop,
  output logic [WORD_W-1:0] rx_rdata,
  input  logic [THR_W-1:0]  rx_thr,
  input  logic [THR_W-1:0]  tx_thr,
  input  logic              xfer_done,
  input  logic              xfer_rdy,
  input  logic              flush_req,
  output logic              flush_busy,
  input  logic              cause_clr_we,
  input  logic [NSTAT-1:0]  cause_clr_bits,
  input  logic              mask_we,
  input  logic [NSTAT-1:0]  mask_wdata,
  output logic [NSTAT-1:0]  status,
  output logic [NSTAT-1:0]  cause,
  output logic              irq
);

  logic [CNT_W-1:0] tx_cnt, rx_cnt;
  logic tx_full, tx_empty, tx_ovf, tx_udf, tx_push_ok, tx_pop_ok;
  logic rx_full, rx_empty, rx_ovf, rx_udf, rx_push_ok, rx_pop_ok;
  logic [7:0] tx_bytes, rx_bytes;
  logic tx_ready, rx_ready;
  logic [NSTAT-1:0] irq_mask, irq_rise;

  // Flush: requested at one edge, applied and self-cleared at the next.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          flush_busy <= 1'b0;
    else if (flush_req)  flush_busy <= 1'b1;
    else                 flush_busy <= 1'b0;
  end

  spi_fifo_track #(.WORD_W(WORD_W), .DEPTH(DEPTH_WORDS)) u_txq (
    .clk(clk), .rst_n(rst_n), .clear(flush_busy),
    .push(tx_push), .wdata(tx_wdata), .pop(tx_pop), .rdata(tx_rdata),
    .count(tx_cnt), .full(tx_full), .empty(tx_empty),
    .ovf(tx_ovf), .udf(tx_udf), .push_ok(tx_push_ok), .pop_ok(tx_pop_ok)
  );

  spi_fifo_track #(.WORD_W(WORD_W), .DEPTH(DEPTH_WORDS)) u_rxq (
    .clk(clk), .rst_n(rst_n), .clear(flush_busy),
    .push(rx_push), .wdata(rx_wdata), .pop(rx_pop), .rdata(rx_rdata),
    .count(rx_cnt), .full(rx_full), .empty(rx_empty),
    .ovf(rx_ovf), .udf(rx_udf), .push_ok(rx_push_ok), .pop_ok(rx_pop_ok)
  );

  assign tx_bytes = occ_bytes(8'(tx_cnt), 8'(BYTES_PW));
  assign rx_bytes = occ_bytes(8'(rx_cnt), 8'(BYTES_PW));
  assign rx_ready = rx_is_ready(rx_bytes, 8'(rx_thr));
  assign tx_ready = tx_is_ready(tx_bytes, 8'(CAP_BYTES), 8'(tx_thr));

  always_comb begin
    status              = '0;
    status[ST_XDONE]    = xfer_done;
    status[ST_XRDY]     = xfer_rdy;
    status[ST_RX_RDY]   = rx_ready;
    status[ST_TX_RDY]   = tx_ready;
    status[ST_RX_EMPTY] = rx_empty;
    status[ST_RX_FULL]  = rx_full;
    status[ST_TX_EMPTY] = tx_empty;
    status[ST_TX_FULL]  = tx_full;
    status[ST_RX_UDF]   = rx_udf;
    status[ST_RX_OVF]   = rx_ovf;
    status[ST_TX_UDF]   = tx_udf;
    status[ST_TX_OVF]   = tx_ovf;
  end

  spi_irq_cause u_irq (
    .clk(clk), .rst_n(rst_n), .status(status),
    .clr_we(cause_clr_we), .clr_bits(cause_clr_bits),
    .mask_we(mask_we), .mask_wdata(mask_wdata),
    .cause(cause), .mask(irq_mask), .irq(irq), .rise(irq_rise)
  );

endmodule

// File: rtl/spi_fifo_irq_chk.sv
module spi_fifo_irq_chk
  import spi_fifo_irq_pkg::*;
#(
  parameter int DEPTH_WORDS = 2,
  localparam int CNT_W = $clog2(DEPTH_WORDS + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NSTAT-1:0] status,
  input logic [NSTAT-1:0] cause,
  input logic [NSTAT-1:0] mask,
  input logic [NSTAT-1:0] rise,
  input logic             irq,
  input logic             flush_req,
  input logic             flush_busy,
  input logic             clr_we,
  input logic [NSTAT-1:0] clr_bits,
  input logic [CNT_W-1:0] tx_cnt,
  input logic [CNT_W-1:0] rx_cnt,
  input logic             tx_push_ok,
  input logic             rx_pop_ok
);

  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt <= CNT_W'(DEPTH_WORDS)) && (rx_cnt <= CNT_W'(DEPTH_WORDS)));

  a_r2_full_empty_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(status[ST_TX_FULL] && status[ST_TX_EMPTY]) && !(status[ST_RX_FULL] && status[ST_RX_EMPTY]));

  a_r2_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_push_ok && !flush_busy && tx_cnt == '0) |=> !status[ST_TX_EMPTY]);

  a_r3_rx_ready_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    status[ST_RX_RDY] |-> !status[ST_RX_EMPTY]);

  a_r5_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(status[ST_TX_OVF]) && !$past(flush_busy)) |-> status[ST_TX_OVF]);

  a_r5_rx_pop_ok_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop_ok |-> !status[ST_RX_EMPTY]);

  a_r6_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    $past(flush_busy) |-> (status[ST_TX_EMPTY] && status[ST_RX_EMPTY] &&
      !status[ST_TX_OVF] && !status[ST_RX_OVF] && !status[ST_TX_UDF] && !status[ST_RX_UDF]));

  a_r6_flush_selfclear: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(flush_busy) && !$past(flush_req)) |-> !flush_busy);

  a_r7_cause_needs_rise: assert property (@(posedge clk) disable iff (!rst_n)
    ((cause & ~$past(cause) & ~$past(rise)) == '0));

  a_r8_clear_applies: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr_we) |-> ((cause & $past(clr_bits) & ~$past(rise)) == '0));

  a_r9_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
    irq == $past(|(cause & mask)));

endmodule

bind spi_fifo_irq_unit spi_fifo_irq_chk #(.DEPTH_WORDS(DEPTH_WORDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .status(status), .cause(cause), .mask(irq_mask),
  .rise(irq_rise), .irq(irq), .flush_req(flush_req), .flush_busy(flush_busy),
  .clr_we(cause_clr_we), .clr_bits(cause_clr_bits),
  .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .tx_push_ok(tx_push_ok), .rx_pop_ok(rx_pop_ok)
);

// File: tb/sim_spi_fifo_irq_unit.sv
`timescale 1ns/1ps
module sim_spi_fifo_irq_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_push = 0, tx_pop = 0, rx_push = 0, rx_pop = 0;
  logic [31:0] tx_wdata = '0, rx_wdata = '0, tx_rdata, rx_rdata;
  logic [2:0]  rx_thr = 3'd3, tx_thr = 3'd3;
  logic        xfer_done = 0, xfer_rdy = 0, flush_req = 0, flush_busy;
  logic        cause_clr_we = 0, mask_we = 0, irq;
  logic [11:0] cause_clr_bits = '0, mask_wdata = '0, status, cause;

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  spi_fifo_irq_unit u0 (
    .clk(clk), .rst_n(rst_n),
    .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_pop(tx_pop), .tx_rdata(tx_rdata),
    .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_pop(rx_pop), .rx_rdata(rx_rdata),
    .rx_thr(rx_thr), .tx_thr(tx_thr), .xfer_done(xfer_done), .xfer_rdy(xfer_rdy),
    .flush_req(flush_req), .flush_busy(flush_busy),
    .cause_clr_we(cause_clr_we), .cause_clr_bits(cause_clr_bits),
    .mask_we(mask_we), .mask_wdata(mask_wdata),
    .status(status), .cause(cause), .irq(irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic tx_wr(logic [31:0] d);
    tx_push = 1; tx_wdata = d; cyc(); tx_push = 0;
  endtask
  task automatic rx_wr(logic [31:0] d);
    rx_push = 1; rx_wdata = d; cyc(); rx_push = 0;
  endtask
  task automatic tx_rd(); tx_pop = 1; cyc(); tx_pop = 0; endtask
  task automatic rx_rd(); rx_pop = 1; cyc(); rx_pop = 0; endtask
  task automatic do_flush(); flush_req = 1; cyc(); flush_req = 0; cyc(); endtask
  task automatic clr(logic [11:0] b);
    cause_clr_we = 1; cause_clr_bits = b; cyc(); cause_clr_we = 0;
  endtask
  task automatic set_mask(logic [11:0] m);
    mask_we = 1; mask_wdata = m; cyc(); mask_we = 0;
  endtask

  initial begin
    #(8 * 20000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 / R4: reset state, tx ready (8 free > 3), both empty
    check("R1 status", 32'(status), 32'h058);
    check("R1 cause", 32'(cause), 0);
    check("R1 irq", 32'(irq), 0);
    check("R1 flush_busy", 32'(flush_busy), 0);
    repeat (3) cyc();
    check("R1 no cause on idle level", 32'(cause), 0);
    set_mask(12'hFFF);
    cyc(); cyc();
    check("R7 unmasked level raises no irq", 32'(irq), 0);
    set_mask(12'h000);

    // R2 / R5 transmit side
    tx_wr(32'hA0A0_0001);
    check("R4 tx one word", 32'(status), 32'h018);
    tx_wr(32'hB0B0_0002);
    check("R4 tx full", 32'(status), 32'h090);
    tx_wr(32'hC0C0_0003);
    check("R5 tx overflow", 32'(status), 32'h890);
    check("R2 tx head", tx_rdata, 32'hA0A0_0001);
    tx_rd();
    check("R2 tx second", tx_rdata, 32'hB0B0_0002);
    tx_rd();
    check("R5 tx ovf sticky empty", 32'(status), 32'h858);
    tx_rd();
    check("R5 tx underflow", 32'(status), 32'hC58);
    flush_req = 1; cyc(); flush_req = 0;
    check("R6 busy set", 32'(flush_busy), 1);
    check("R6 not yet applied", 32'(status), 32'hC58);
    cyc();
    check("R6 busy self-clear", 32'(flush_busy), 0);
    check("R6 flushed status", 32'(status), 32'h058);

    // R2 / R5 receive side
    tx_wr(32'h1);
    rx_wr(32'h1111_0001);
    rx_wr(32'h2222_0002);
    check("R4 rx full", 32'(status), 32'h02C);
    rx_wr(32'h3333_0003);
    check("R5 rx overflow", 32'(status[9]), 1);
    check("R2 rx head", rx_rdata, 32'h1111_0001);
    rx_rd();
    check("R2 rx second", rx_rdata, 32'h2222_0002);
    rx_rd();
    rx_rd();
    check("R5 rx underflow", 32'(status[9:8]), 32'h3);
    do_flush();
    check("R6 flush both", 32'(status), 32'h058);

    // R2 push and pop together while full
    tx_wr(32'hA); tx_wr(32'hB);
    tx_push = 1; tx_pop = 1; tx_wdata = 32'hC; cyc(); tx_push = 0; tx_pop = 0;
    check("R2 push+pop full no ovf", 32'(status), 32'h090);
    check("R2 head after push+pop", tx_rdata, 32'hB);
    tx_rd();
    check("R2 tail after push+pop", tx_rdata, 32'hC);
    do_flush();
    cyc(); cyc();
    clr(12'hFFF);
    check("R8 all ones clears", 32'(cause), 0);

    // R7 / R8 / R9 cause and irq
    set_mask(12'h001);
    xfer_done = 1; cyc();
    check("R7 cause on rise", 32'(cause), 32'h001);
    check("R9 irq lags cause", 32'(irq), 0);
    cyc();
    check("R9 irq set", 32'(irq), 1);
    clr(12'h001);
    check("R8 clear one", 32'(cause), 0);
    cyc();
    check("R9 irq drops", 32'(irq), 0);
    check("R7 held level no recapture", 32'(cause), 0);
    xfer_done = 0; cyc();
    xfer_done = 1; clr(12'h001);
    check("R8 rise wins over clear", 32'(cause), 32'h001);
    set_mask(12'h000);
    cyc();
    check("R9 zero mask blocks", 32'(irq), 0);
    xfer_rdy = 1; cyc();
    check("R7 second cause", 32'(cause), 32'h003);
    clr(12'h002);
    check("R8 selective clear", 32'(cause), 32'h001);
    set_mask(12'h002);
    cyc();
    check("R7 unmask held level no irq", 32'(irq), 0);
    xfer_done = 0; xfer_rdy = 0;
    clr(12'hFFF);
    check("R8 cleared before fifo test", 32'(cause), 0);
    tx_wr(32'h5);
    tx_rd();
    check("R7 no cause same edge", 32'(cause), 0);
    cyc();
    check("R7 tx empty rise cause", 32'(cause), 32'h040);

    // R3 threshold sweep over occupancy and thresholds
    for (int w = 0; w <= 2; w++) begin
      do_flush();
      for (int k = 0; k < w; k++) begin
        tx_wr(32'(k)); rx_wr(32'(k));
      end
      for (int t = 0; t < 8; t++) begin
        rx_thr = 3'(t); tx_thr = 3'(t);
        #1;
        check($sformatf("R3 rx ready w%0d t%0d", w, t), 32'(status[2]), 32'((w * 4) > t));
        check($sformatf("R3 tx ready w%0d t%0d", w, t), 32'(status[3]), 32'((8 - w * 4) > t));
        @(negedge clk);
      end
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule